// File: doc/BRIEF.md
# Three-Tape Sequential Machine Controller

This block is the control core of an 8-bit machine that has no addressable memory. Everything it touches is a sequential tape: a code tape of 4-bit symbols, a data tape of bytes and an I/O tape of bytes. Each tape sits outside the block and keeps its own head. The controller never sends an address. It only sees the symbol or byte under each head, and it drives step-forward, step-backward and write strobes plus one rewind strobe that returns all three heads to cell 0. Every tape model updates on the rising clock edge that samples its strobe.

The controller fetches one opcode at a time. Its state machine has the states FETCH, DECODE, WRITE, NEXT, SCAN, HALT and HOME. FETCH latches the code symbol and always goes to DECODE. From DECODE the machine goes to WRITE for the four byte operations and to SCAN when a bracket must jump. It goes to HALT for the halt and end-of-program codes, to HOME for restart, and to NEXT for everything else. WRITE goes to NEXT. NEXT steps the code head and returns to FETCH. SCAN waits for the bracket scanner to finish and then goes to NEXT. HOME goes to FETCH. HALT holds until reset.

A swap flag picks whether the move opcodes step the data tape or the I/O tape. Increment, decrement and the two copy operations ignore the flag. A separate bracket scanner walks the code tape with a nesting counter whenever a loop must jump.

Top module: `seqtape_ctrl`

## Requirements
- R1: While reset is low, `halted`, `swap` and every strobe output are 0. After reset the first opcode is fetched from the cell under the code head.
- R2: Opcode 1 inverts `swap`. Nothing else changes `swap` except restart, which clears it.
- R3: Opcode 2 (forward) and opcode 3 (backward) step the data head by one when `swap`=0 and the I/O head by one when `swap`=1. The other tape's head does not move.
- R4: Opcode 4 adds 1 and opcode 5 subtracts 1, modulo 256, to the byte under the data head, whatever the value of `swap`.
- R5: Opcode 6 copies the data byte under its head into the I/O cell under its head. Opcode 7 copies the I/O cell into the data cell.
- R6: In any cycle at most one of the step-forward, step-backward, read-capture and write strobes is active, counted over all tapes together.
- R7: Opcodes 0 to 3 and 10, 13 and 15 take 3 clock cycles and opcodes 4 to 7 take 4. After each of them the code head advances by exactly one. A byte write always follows a byte capture in the cycle before.
- R8: Opcode 8 with a zero data byte moves the code head past the matching opcode 9, counting nested pairs. With a nonzero data byte it just advances.
- R9: Opcode 9 with a nonzero data byte moves the code head to just after the matching opcode 8. With a zero data byte it just advances.
- R10: Opcodes 14 (halt) and 11 (end of program) raise `halted` two cycles after the fetch. From then on no strobe fires until reset, and the code head stays on the halting cell.
- R11: Opcode 12 (restart) pulses `home` for one cycle, clears `swap` and resumes fetching at code cell 0. Tape contents are kept.
- R12: Opcodes 0, 10, 13 and 15 change no tape and no flag. They only advance the code head.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| code_op | input | 4 | Symbol under the code head |
| code_fw | output | 1 | Step code head forward |
| code_bk | output | 1 | Step code head backward |
| dat_q | input | 8 | Byte under the data head |
| dat_fw | output | 1 | Step data head forward |
| dat_bk | output | 1 | Step data head backward |
| dat_wr | output | 1 | Write `dat_d` into the data cell |
| dat_d | output | 8 | Byte to write on the data tape |
| io_q | input | 8 | Byte under the I/O head |
| io_fw | output | 1 | Step I/O head forward |
| io_bk | output | 1 | Step I/O head backward |
| io_wr | output | 1 | Write `io_d` into the I/O cell |
| io_d | output | 8 | Byte to write on the I/O tape |
| home | output | 1 | Rewind all three heads to cell 0 |
| swap | output | 1 | Move target: 0 data tape, 1 I/O tape |
| halted | output | 1 | Machine stopped |

## Verification
The assertions check the per-cycle rules on every cycle: strobe exclusivity, a write always following a capture, move routing against the swap flag, the only legal causes of a swap change, and quiet strobes with `halted` held once the machine has stopped. The assertions cannot show whole-program effects. Bracket matching across nested loops, wrap of bytes at 0 and 255, the copy direction of the transfer opcodes and the exact cycle cost of straight-line code are checked only by the bench. It runs random and directed programs against its own interpreter and compares final tapes, heads, flag and cycle count.

// File: rtl/tape_pkg.sv
package tape_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP     = 4'd0,
        OP_SWAP    = 4'd1,
        OP_FWD     = 4'd2,
        OP_BWD     = 4'd3,
        OP_INC     = 4'd4,
        OP_DEC     = 4'd5,
        OP_OUT     = 4'd6,
        OP_IN      = 4'd7,
        OP_OPEN    = 4'd8,
        OP_CLOSE   = 4'd9,
        OP_RSVD    = 4'd10,
        OP_END     = 4'd11,
        OP_RESTART = 4'd12,
        OP_EOF     = 4'd13,
        OP_HALT    = 4'd14,
        OP_SPARE   = 4'd15
    } tape_op_e;

    typedef enum logic [1:0] {
        WM_COPY,
        WM_INC,
        WM_DEC
    } wr_mode_e;

    typedef enum logic [2:0] {
        S_FETCH,
        S_DECODE,
        S_WRITE,
        S_NEXT,
        S_SCAN,
        S_HALT,
        S_HOME
    } ctl_state_e;

    typedef enum logic [1:0] {
        SC_IDLE,
        SC_STEP,
        SC_LOOK
    } scan_state_e;
endpackage

// File: rtl/tape_bracket_scan.sv
module tape_bracket_scan
    import tape_pkg::*;
#(
    parameter int DEPTH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            back_in,
    input  logic [OP_W-1:0] code_op,
    output logic            step_fw,
    output logic            step_bk,
    output logic            done
);
    localparam logic [DEPTH_W-1:0] ONE = DEPTH_W'(1);

    scan_state_e        sc_q, sc_nx;
    logic [DEPTH_W-1:0] depth_q;
    logic               back_q;
    logic               is_same, is_opp;

    // "same" brackets deepen the nest, "opposite" ones close it
    assign is_same = (code_op == (back_q ? OP_CLOSE : OP_OPEN));
    assign is_opp  = (code_op == (back_q ? OP_OPEN : OP_CLOSE));
    assign done    = (sc_q == SC_LOOK) && is_opp && (depth_q == ONE);

    always_ff @(posedge clk) begin
        if (!rst_n) sc_q <= SC_IDLE;
        else        sc_q <= sc_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q <= '0;
            back_q  <= 1'b0;
        end else if (sc_q == SC_IDLE && start) begin
            depth_q <= ONE;
            back_q  <= back_in;
        end else if (sc_q == SC_LOOK) begin
            if (is_same)     depth_q <= depth_q + ONE;
            else if (is_opp) depth_q <= depth_q - ONE;
        end
    end

    always_comb begin
        sc_nx   = sc_q;
        step_fw = 1'b0;
        step_bk = 1'b0;
        unique case (sc_q)
            SC_IDLE: if (start) sc_nx = SC_STEP;
            SC_STEP: begin
                step_fw = !back_q;
                step_bk = back_q;
                sc_nx   = SC_LOOK;
            end
            SC_LOOK: sc_nx = done ? SC_IDLE : SC_STEP;
            default: sc_nx = SC_IDLE;
        endcase
    end

    // R8: a search is never restarted while one is in progress
    p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (sc_q == SC_IDLE));

    // R9: while searching, the nest level is never empty
    p_depth_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_q != SC_IDLE) |-> (depth_q != '0));
endmodule

// File: rtl/tape_byte_unit.sv
module tape_byte_unit
    import tape_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              cap_from_io,
    input  logic [BYTE_W-1:0] dat_q,
    input  logic [BYTE_W-1:0] io_q,
    input  logic              wr_en,
    input  logic              wr_to_io,
    input  wr_mode_e          wr_mode,
    output logic              dat_wr,
    output logic              io_wr,
    output logic [BYTE_W-1:0] wr_byte
);
    logic [BYTE_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      hold_q <= '0;
        else if (cap_en) hold_q <= cap_from_io ? io_q : dat_q;
    end

    always_comb begin
        unique case (wr_mode)
            WM_INC:  wr_byte = hold_q + BYTE_W'(1);
            WM_DEC:  wr_byte = hold_q - BYTE_W'(1);
            default: wr_byte = hold_q;
        endcase
    end

    assign dat_wr = wr_en && !wr_to_io;
    assign io_wr  = wr_en && wr_to_io;

    // R7: every write is preceded by a capture in the previous cycle
    p_write_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(cap_en));
endmodule

// File: rtl/tape_ctl_fsm.sv
module tape_ctl_fsm
    import tape_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] code_op,
    input  logic            dat_zero,
    input  logic            scan_done,
    output logic            code_fw,
    output logic            dat_fw,
    output logic            dat_bk,
    output logic            io_fw,
    output logic            io_bk,
    output logic            cap_en,
    output logic            cap_from_io,
    output logic            wr_en,
    output logic            wr_to_io,
    output wr_mode_e        wr_mode,
    output logic            scan_start,
    output logic            scan_back,
    output logic            home,
    output logic            halted,
    output logic            swap
);
    ctl_state_e state, state_nx;
    tape_op_e   ir;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_FETCH;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir   <= OP_NOP;
            swap <= 1'b0;
        end else begin
            if (state == S_FETCH) ir <= tape_op_e'(code_op);
            if (state == S_HOME) swap <= 1'b0;
            else if (state == S_DECODE && ir == OP_SWAP) swap <= !swap;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_FETCH:  state_nx = S_DECODE;
            S_DECODE: begin
                case (ir)
                    OP_INC, OP_DEC, OP_OUT, OP_IN: state_nx = S_WRITE;
                    OP_OPEN:          state_nx = dat_zero ? S_SCAN : S_NEXT;
                    OP_CLOSE:         state_nx = dat_zero ? S_NEXT : S_SCAN;
                    OP_HALT, OP_END:  state_nx = S_HALT;
                    OP_RESTART:       state_nx = S_HOME;
                    default:          state_nx = S_NEXT;
                endcase
            end
            S_WRITE:  state_nx = S_NEXT;
            S_NEXT:   state_nx = S_FETCH;
            S_SCAN:   if (scan_done) state_nx = S_NEXT;
            S_HALT:   state_nx = S_HALT;
            S_HOME:   state_nx = S_FETCH;
            default:  state_nx = S_FETCH;
        endcase
    end

    always_comb begin
        code_fw     = 1'b0;
        dat_fw      = 1'b0;
        dat_bk      = 1'b0;
        io_fw       = 1'b0;
        io_bk       = 1'b0;
        cap_en      = 1'b0;
        cap_from_io = 1'b0;
        wr_en       = 1'b0;
        wr_to_io    = 1'b0;
        wr_mode     = WM_COPY;
        scan_start  = 1'b0;
        scan_back   = 1'b0;
        home        = 1'b0;
        halted      = 1'b0;
        unique case (state)
            S_DECODE: begin
                case (ir)
                    OP_FWD: begin
                        dat_fw = !swap;
                        io_fw  = swap;
                    end
                    OP_BWD: begin
                        dat_bk = !swap;
                        io_bk  = swap;
                    end
                    OP_INC, OP_DEC, OP_OUT: cap_en = 1'b1;
                    OP_IN: begin
                        cap_en      = 1'b1;
                        cap_from_io = 1'b1;
                    end
                    OP_OPEN:  scan_start = dat_zero;
                    OP_CLOSE: begin
                        scan_start = !dat_zero;
                        scan_back  = 1'b1;
                    end
                    default: ;
                endcase
            end
            S_WRITE: begin
                wr_en = 1'b1;
                case (ir)
                    OP_INC:  wr_mode  = WM_INC;
                    OP_DEC:  wr_mode  = WM_DEC;
                    OP_OUT:  wr_to_io = 1'b1;
                    default: ;
                endcase
            end
            S_NEXT:  code_fw = 1'b1;
            S_HALT:  halted  = 1'b1;
            S_HOME:  home    = 1'b1;
            default: ;
        endcase
    end

    // R2: the flag only changes by a swap opcode or by a restart
    p_swap_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(swap) |-> (($past(state) == S_DECODE && $past(ir) == OP_SWAP)
                            || $past(state) == S_HOME));

    // R11: after the rewind pulse the flag is clear and fetching resumes
    p_home_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        home |=> (!swap && !home && state == S_FETCH));
endmodule

// File: rtl/seqtape_ctrl.sv
module seqtape_ctrl
    import tape_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int DEPTH_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   code_op,
    output logic              code_fw,
    output logic              code_bk,
    input  logic [BYTE_W-1:0] dat_q,
    output logic              dat_fw,
    output logic              dat_bk,
    output logic              dat_wr,
    output logic [BYTE_W-1:0] dat_d,
    input  logic [BYTE_W-1:0] io_q,
    output logic              io_fw,
    output logic              io_bk,
    output logic              io_wr,
    output logic [BYTE_W-1:0] io_d,
    output logic              home,
    output logic              swap,
    output logic              halted
);
    logic     ctl_code_fw, sc_fw, sc_bk, scan_done, scan_start, scan_back;
    logic     cap_en, cap_from_io, wr_en, wr_to_io, dat_zero;
    logic     [BYTE_W-1:0] wr_byte;
    wr_mode_e wr_mode;

    assign dat_zero = (dat_q == '0);

    tape_ctl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .code_op     (code_op),
        .dat_zero    (dat_zero),
        .scan_done   (scan_done),
        .code_fw     (ctl_code_fw),
        .dat_fw      (dat_fw),
        .dat_bk      (dat_bk),
        .io_fw       (io_fw),
        .io_bk       (io_bk),
        .cap_en      (cap_en),
        .cap_from_io (cap_from_io),
        .wr_en       (wr_en),
        .wr_to_io    (wr_to_io),
        .wr_mode     (wr_mode),
        .scan_start  (scan_start),
        .scan_back   (scan_back),
        .home        (home),
        .halted      (halted),
        .swap        (swap)
    );

    tape_bracket_scan #(.DEPTH_W(DEPTH_W)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (scan_start),
        .back_in (scan_back),
        .code_op (code_op),
        .step_fw (sc_fw),
        .step_bk (sc_bk),
        .done    (scan_done)
    );

    tape_byte_unit #(.BYTE_W(BYTE_W)) u_byte (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_en      (cap_en),
        .cap_from_io (cap_from_io),
        .dat_q       (dat_q),
        .io_q        (io_q),
        .wr_en       (wr_en),
        .wr_to_io    (wr_to_io),
        .wr_mode     (wr_mode),
        .dat_wr      (dat_wr),
        .io_wr       (io_wr),
        .wr_byte     (wr_byte)
    );

    assign code_fw = ctl_code_fw || sc_fw;
    assign code_bk = sc_bk;
    assign dat_d   = wr_byte;
    assign io_d    = wr_byte;

    // R6: one strobe class at a time across all three tapes
    p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({code_fw || dat_fw || io_fw, code_bk || dat_bk || io_bk,
                  cap_en, dat_wr || io_wr}));

    // R3: moves go only to the tape the swap flag selects
    p_move_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((dat_fw || dat_bk) |-> !swap) and ((io_fw || io_bk) |-> swap));

    // R10: a stopped machine stays stopped and silent
    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!code_fw && !code_bk && !dat_fw && !dat_bk && !dat_wr
                    && !io_fw && !io_bk && !io_wr && !home));
    p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
endmodule

// File: tb/test_seqtape_ctrl.sv
module test_seqtape_ctrl;
    localparam int CELLS = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] code_op;
    logic       code_fw, code_bk, dat_fw, dat_bk, dat_wr, io_fw, io_bk, io_wr;
    logic [7:0] dat_q, dat_d, io_q, io_d;
    logic       home, swap, halted;

    always #5 clk = !clk;

    seqtape_ctrl i_seqtape_ctrl (
        .clk(clk), .rst_n(rst_n), .code_op(code_op), .code_fw(code_fw),
        .code_bk(code_bk), .dat_q(dat_q), .dat_fw(dat_fw), .dat_bk(dat_bk),
        .dat_wr(dat_wr), .dat_d(dat_d), .io_q(io_q), .io_fw(io_fw),
        .io_bk(io_bk), .io_wr(io_wr), .io_d(io_d), .home(home),
        .swap(swap), .halted(halted)
    );

    // tape models: arrays with wrapping head counters
    logic [3:0] code_m [CELLS];
    logic [7:0] dat_m  [CELLS];
    logic [7:0] io_m   [CELLS];
    logic [5:0] ch, dh, ih;

    assign code_op = code_m[ch];
    assign dat_q   = dat_m[dh];
    assign io_q    = io_m[ih];

    always @(posedge clk) begin
        if (!rst_n) begin
            ch <= '0; dh <= '0; ih <= '0;
        end else if (home) begin
            ch <= '0; dh <= '0; ih <= '0;
        end else begin
            if (code_fw) ch <= ch + 6'd1;
            if (code_bk) ch <= ch - 6'd1;
            if (dat_fw)  dh <= dh + 6'd1;
            if (dat_bk)  dh <= dh - 6'd1;
            if (io_fw)   ih <= ih + 6'd1;
            if (io_bk)   ih <= ih - 6'd1;
            if (dat_wr)  dat_m[dh] <= dat_d;
            if (io_wr)   io_m[ih]  <= io_d;
        end
    end

    int n_run = 0, n_fail = 0, multi_cnt = 0, home_cnt = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if ($countones({code_fw, code_bk, dat_fw, dat_bk, dat_wr,
                            io_fw, io_bk, io_wr}) > 1) multi_cnt++;
            if (home) home_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // program and initial tape images, reference results
    logic [3:0] prog     [CELLS];
    logic [7:0] init_dat [CELLS];
    logic [7:0] init_io  [CELLS];
    logic [7:0] ref_dat  [CELLS];
    logic [7:0] ref_io   [CELLS];
    logic [5:0] ref_ch, ref_dh, ref_ih;
    bit         ref_swap;
    int         ref_cyc;

    // bench interpreter written from the requirements
    task automatic ref_run();
        int steps = 0;
        bit stop = 0;
        for (int i = 0; i < CELLS; i++) begin
            ref_dat[i] = init_dat[i];
            ref_io[i]  = init_io[i];
        end
        ref_ch = 0; ref_dh = 0; ref_ih = 0; ref_swap = 0; ref_cyc = 0;
        while (!stop && steps < 3000) begin
            steps++;
            case (prog[ref_ch])
                4'd1: begin ref_swap = !ref_swap; ref_ch++; ref_cyc += 3; end
                4'd2: begin if (ref_swap) ref_ih++; else ref_dh++; ref_ch++; ref_cyc += 3; end
                4'd3: begin if (ref_swap) ref_ih--; else ref_dh--; ref_ch++; ref_cyc += 3; end
                4'd4: begin ref_dat[ref_dh] = ref_dat[ref_dh] + 8'd1; ref_ch++; ref_cyc += 4; end
                4'd5: begin ref_dat[ref_dh] = ref_dat[ref_dh] - 8'd1; ref_ch++; ref_cyc += 4; end
                4'd6: begin ref_io[ref_ih] = ref_dat[ref_dh]; ref_ch++; ref_cyc += 4; end
                4'd7: begin ref_dat[ref_dh] = ref_io[ref_ih]; ref_ch++; ref_cyc += 4; end
                4'd8: begin
                    if (ref_dat[ref_dh] == 0) begin
                        int d = 1;
                        while (d > 0) begin
                            ref_ch++;
                            if (prog[ref_ch] == 4'd8) d++;
                            if (prog[ref_ch] == 4'd9) d--;
                        end
                    end
                    ref_ch++;
                end
                4'd9: begin
                    if (ref_dat[ref_dh] != 0) begin
                        int d = 1;
                        while (d > 0) begin
                            ref_ch--;
                            if (prog[ref_ch] == 4'd9) d++;
                            if (prog[ref_ch] == 4'd8) d--;
                        end
                    end
                    ref_ch++;
                end
                4'd11, 4'd14: begin stop = 1; ref_cyc += 2; end
                4'd12: begin
                    ref_ch = 0; ref_dh = 0; ref_ih = 0; ref_swap = 0; ref_cyc += 3;
                end
                default: begin ref_ch++; ref_cyc += 3; end
            endcase
        end
    endtask

    task automatic run_prog(input string req, input bit chk_cyc, input int exp_home);
        int cyc = 0;
        int bad;
        logic [5:0] sch, sdh, sih;
        rst_n = 1'b0;
        for (int i = 0; i < CELLS; i++) begin
            code_m[i] = prog[i];
            dat_m[i]  = init_dat[i];
            io_m[i]   = init_io[i];
        end
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        home_cnt = 0;
        ref_run();
        while (!halted && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        check(halted, req, "halted after run (R10)", int'(halted), 1);
        bad = -1;
        for (int i = CELLS - 1; i >= 0; i--) if (dat_m[i] !== ref_dat[i]) bad = i;
        check(bad < 0, req, "data tape first bad cell (R4 R5)", bad, -1);
        bad = -1;
        for (int i = CELLS - 1; i >= 0; i--) if (io_m[i] !== ref_io[i]) bad = i;
        check(bad < 0, req, "io tape first bad cell (R5)", bad, -1);
        check(dh == ref_dh, req, "data head (R3)", int'(dh), int'(ref_dh));
        check(ih == ref_ih, req, "io head (R3)", int'(ih), int'(ref_ih));
        check(ch == ref_ch, req, "code head (R8 R9)", int'(ch), int'(ref_ch));
        check(swap == ref_swap, req, "swap flag (R2)", int'(swap), int'(ref_swap));
        if (chk_cyc) check(cyc == ref_cyc, req, "cycles to halt (R7)", cyc, ref_cyc);
        if (exp_home >= 0) check(home_cnt == exp_home, req, "home pulses (R11)", home_cnt, exp_home);
        // R10: nothing moves or changes once halted
        sch = ch; sdh = dh; sih = ih;
        repeat (6) @(negedge clk);
        check(halted && ch == sch && dh == sdh && ih == sih, req,
              "heads frozen while halted (R10)", int'({ch, dh, ih}), int'({sch, sdh, sih}));
        check(multi_cnt == 0, req, "cycles with >1 strobe (R6)", multi_cnt, 0);
    endtask

    task automatic clear_all();
        for (int i = 0; i < CELLS; i++) begin
            prog[i] = 4'd14; init_dat[i] = 8'd0; init_io[i] = 8'd0;
        end
    endtask

    task automatic put(input int idx, input logic [3:0] op);
        prog[idx] = op;
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        n_run++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int seed_val;
        logic [3:0] pool [11];
        pool = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd10, 4'd13, 4'd15};
        seed_val = $urandom(32'd20240917);

        // R1: quiet during reset
        clear_all();
        for (int i = 0; i < CELLS; i++) code_m[i] = 4'd2;
        repeat (3) @(negedge clk);
        check(!halted && !swap && !home, "R1", "flags in reset", int'({halted, swap, home}), 0);
        check({code_fw, code_bk, dat_fw, dat_bk, dat_wr, io_fw, io_bk, io_wr} == 8'd0,
              "R1", "strobes in reset",
              int'({code_fw, code_bk, dat_fw, dat_bk, dat_wr, io_fw, io_bk, io_wr}), 0);

        // R2 R3: swap steering of moves; R12 no-op codes
        clear_all();
        put(0, 4'd2); put(1, 4'd2); put(2, 4'd1); put(3, 4'd2); put(4, 4'd3);
        put(5, 4'd3); put(6, 4'd1); put(7, 4'd3); put(8, 4'd0); put(9, 4'd10);
        put(10, 4'd13); put(11, 4'd15); put(12, 4'd1);
        run_prog("R2 R3 R12", 1'b1, 0);

        // R4: wrap at both ends, swap set does not redirect increments
        clear_all();
        init_dat[0] = 8'hFF; init_dat[1] = 8'h00;
        put(0, 4'd4); put(1, 4'd2); put(2, 4'd1); put(3, 4'd5); put(4, 4'd5);
        put(5, 4'd4);
        run_prog("R4", 1'b1, 0);

        // R5: output then input across shifted heads; R10 end marker 11
        clear_all();
        init_dat[0] = 8'h5A; init_io[1] = 8'hC3;
        put(0, 4'd1); put(1, 4'd2); put(2, 4'd6); put(3, 4'd2); put(4, 4'd7);
        put(5, 4'd1); put(6, 4'd2); put(7, 4'd7); put(8, 4'd11);
        run_prog("R5 R10", 1'b1, 0);

        // R8 R9: nested loops, inner runs three times per outer pass
        clear_all();
        put(0, 4'd4); put(1, 4'd4); put(2, 4'd8); put(3, 4'd2); put(4, 4'd4);
        put(5, 4'd4); put(6, 4'd4); put(7, 4'd8); put(8, 4'd2); put(9, 4'd4);
        put(10, 4'd3); put(11, 4'd5); put(12, 4'd9); put(13, 4'd3); put(14, 4'd5);
        put(15, 4'd9);
        run_prog("R8 R9", 1'b0, 0);

        // R9: close on zero falls through; R8: open on nonzero enters
        clear_all();
        put(0, 4'd9); put(1, 4'd4); put(2, 4'd8); put(3, 4'd14); put(4, 4'd9);
        put(5, 4'd5);
        run_prog("R8 R9", 1'b0, 0);

        // R11: skip-loop, then restart with swap set, then halt inside loop
        clear_all();
        put(0, 4'd8); put(1, 4'd14); put(2, 4'd9); put(3, 4'd4); put(4, 4'd1);
        put(5, 4'd2); put(6, 4'd12);
        run_prog("R11 R8", 1'b0, 1);

        // R7 R12: random straight-line programs on random tapes
        for (int t = 0; t < 24; t++) begin
            int len;
            clear_all();
            for (int i = 0; i < CELLS; i++) begin
                init_dat[i] = 8'($urandom);
                init_io[i]  = 8'($urandom);
            end
            if (t % 3 == 0) begin
                init_dat[0] = 8'hFF; init_dat[63] = 8'h00;
            end
            len = 8 + int'($urandom % 50);
            for (int i = 0; i < len; i++) prog[i] = pool[$urandom % 11];
            prog[len] = ($urandom % 2 == 0) ? 4'd14 : 4'd11;
            run_prog("R7 R12 random", 1'b1, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule